// File: doc/BRIEF.md
# Virtual Address Segment Decoder

This block sorts every 64-bit virtual address that a processor core issues into one of four outcomes, based on the current privilege state. The address may be passed straight through to a physical address. It may be sent on to the translation lookaside buffer. It may also be refused as an address error, and the refusal is reported as a load error or a store error. The decision uses several inputs together:

- the address itself;
- whether the access is a read or a write;
- the two-bit privilege field;
- the exception-level flag and the error-level flag;
- one enable per privilege mode that selects full 64-bit addressing. When that enable is off, the low 32 bits are sign-extended.

The decoder has no handshake. A new address can be presented on every clock. The code and the physical address appear on the outputs one clock later, held in a single output register. Inside, the address passes through a priority chain of named regions:

- `RG_ERL_LOW`: the error-level identity window.
- `RG_PHYS_WIN`: the wide physical window.
- `RG_KDIRECT`: the kernel direct window.
- `RG_MAPPED`: the address goes to the translation buffer.
- `RG_BAD`: an address error.

The output register moves from its reset value to the code of the region chosen on each clock.

Top module: `vaseg_decoder`

## Requirements
- R1: While reset is asserted, or asynchronously as soon as it is asserted, `res_o` is 01 and `pa_o` is zero.
- R2: The result codes are 00 direct, 01 translate, 10 load address error, 11 store address error. A result appears exactly one rising clock edge after its inputs, and the outputs keep their old value until that edge.
- R3: If the exception-level or error-level flag is set, the access is decoded as kernel whatever the privilege field holds. In kernel state, the kernel wide-enable picks 32- or 64-bit decoding.
- R4: With both flags clear, a privilege field of 01 or 11 gives an address error: code 11 for a write and code 10 for a read.
- R5: In kernel state with the error-level flag set, an undecoded address no greater than 0x7fffffff is direct, with the low 31 bits as the physical address. This rule is checked on the raw address and takes priority over every other region.
- R6: In kernel state, an undecoded address whose bits 63:62 are 10 is direct, and the physical address is the low 44 bits. This rule is checked on the raw address, even when the kernel wide-enable is off. In user state the same address gets no special treatment.
- R7: When the wide-enable of the effective mode is off, the address is replaced by the sign extension of its low 32 bits, and the user region ends at 0x7fffffff.
- R8: When the wide-enable is on, the user region ends at 0xffffffffff. Addresses up to and including the user top are sent to translation (code 01).
- R9: In kernel state, a normalised address from 0xffffffff80000000 to 0xffffffffbfffffff is direct, with its low 29 bits as the physical address.
- R10: In kernel state, a normalised address above the user top that lies outside every direct window is sent to translation.
- R11: In user state, an address above the user top is an address error: code 11 for a write and code 10 for a read.
- R12: `pa_o` is zero whenever `res_o` is not 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| va_i | input | 64 | Virtual address |
| wr_i | input | 1 | 1 = store access, 0 = load access |
| mode_i | input | 2 | Privilege field: 00 kernel, 10 user, others refused |
| exl_i | input | 1 | Exception-level flag |
| erl_i | input | 1 | Error-level flag |
| ux_i | input | 1 | 64-bit addressing enable for user state |
| kx_i | input | 1 | 64-bit addressing enable for kernel state |
| res_o | output | 2 | Result code |
| pa_o | output | 64 | Physical address, meaningful for code 00 |

## Verification
The error-level identity window and the user translation region overlap. A kernel address below 2 GB with the error-level flag set qualifies for both, and the window must win. The bench provokes this case with the flag set and also with only the exception-level flag set. It expects a direct result carrying the low 31 bits in the first case and a translate result in the second. A second overlap is also driven: the wide physical window competing with the 32-bit sign extension when the kernel wide-enable is off. Here the bench expects the raw-address window to take precedence.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

    typedef enum logic [1:0] {
        RES_DIRECT = 2'b00,
        RES_TLB    = 2'b01,
        RES_ADEL   = 2'b10,
        RES_ADES   = 2'b11
    } vaseg_res_e;

    typedef enum logic [2:0] {
        RG_ERL_LOW,
        RG_PHYS_WIN,
        RG_KDIRECT,
        RG_MAPPED,
        RG_BAD
    } vaseg_region_e;

    localparam logic [1:0] PRIV_KERNEL = 2'b00;
    localparam logic [1:0] PRIV_SUPER  = 2'b01;
    localparam logic [1:0] PRIV_USER   = 2'b10;

endpackage

// File: rtl/vaseg_mode.sv
// Resolves the effective privilege state and the width enable that applies.
module vaseg_mode
    import vaseg_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       exl_i,
    input  logic       erl_i,
    input  logic       ux_i,
    input  logic       kx_i,
    output logic       is_kernel_o,
    output logic       is_user_o,
    output logic       is_bad_o,
    output logic       wide_o
);

    always_comb begin
        is_kernel_o = 1'b0;
        is_user_o   = 1'b0;
        is_bad_o    = 1'b0;
        if (exl_i || erl_i) begin
            is_kernel_o = 1'b1;
        end else begin
            unique case (mode_i)
                PRIV_KERNEL: is_kernel_o = 1'b1;
                PRIV_USER:   is_user_o   = 1'b1;
                default:     is_bad_o    = 1'b1;
            endcase
        end
    end

    always_comb begin
        if (is_kernel_o)
            wide_o = kx_i;
        else if (is_user_o)
            wide_o = ux_i;
        else
            wide_o = 1'b0;
    end

endmodule

// File: rtl/vaseg_norm.sv
// Narrows the address to a sign-extended 32-bit value when wide mode is off
// and compares it against the user region top.
module vaseg_norm #(
    parameter int VA_W      = 64,
    parameter int NARROW_W  = 32,
    parameter int WIDE_USER = 40
) (
    input  logic [VA_W-1:0] va_i,
    input  logic            wide_i,
    output logic [VA_W-1:0] va_n_o,
    output logic            in_user_o
);

    localparam int EXT_W = VA_W - NARROW_W;

    localparam logic [VA_W-1:0] TOP_NARROW =
        {{(EXT_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
    localparam logic [VA_W-1:0] TOP_WIDE =
        {{(VA_W-WIDE_USER){1'b0}}, {WIDE_USER{1'b1}}};

    logic [VA_W-1:0] top;

    always_comb begin
        if (wide_i) begin
            va_n_o = va_i;
            top    = TOP_WIDE;
        end else begin
            va_n_o = {{EXT_W{va_i[NARROW_W-1]}}, va_i[NARROW_W-1:0]};
            top    = TOP_NARROW;
        end
        in_user_o = (va_n_o <= top);
    end

endmodule

// File: rtl/vaseg_region.sv
// Priority chain that picks a region, then a region-to-result output map.
module vaseg_region
    import vaseg_pkg::*;
#(
    parameter int VA_W     = 64,
    parameter int PA_W     = 64,
    parameter int PHYS_BITS = 44,
    parameter int KDIR_BITS = 29,
    parameter int ERL_BITS  = 31
) (
    input  logic [VA_W-1:0] va_raw_i,
    input  logic [VA_W-1:0] va_n_i,
    input  logic            in_user_i,
    input  logic            is_kernel_i,
    input  logic            is_bad_i,
    input  logic            erl_i,
    input  logic            wr_i,
    output vaseg_res_e      res_o,
    output logic [PA_W-1:0] pa_o
);

    localparam logic [VA_W-1:0] ERL_TOP = {{(VA_W-ERL_BITS){1'b0}}, {ERL_BITS{1'b1}}};
    localparam logic [VA_W-1:0] KD_LO   = {{(VA_W-31){1'b1}}, 31'b0};
    localparam logic [VA_W-1:0] KD_HI   = {{(VA_W-31){1'b1}}, 1'b0, {30{1'b1}}};

    logic          hit_erl;
    logic          hit_phys;
    logic          hit_kdir;
    vaseg_region_e region;

    assign hit_erl  = is_kernel_i && erl_i && (va_raw_i <= ERL_TOP);
    assign hit_phys = is_kernel_i && (va_raw_i[VA_W-1 -: 2] == 2'b10);
    assign hit_kdir = is_kernel_i && (va_n_i >= KD_LO) && (va_n_i <= KD_HI);

    // region selection
    always_comb begin
        if (is_bad_i)
            region = RG_BAD;
        else if (hit_erl)
            region = RG_ERL_LOW;
        else if (hit_phys)
            region = RG_PHYS_WIN;
        else if (in_user_i)
            region = RG_MAPPED;
        else if (hit_kdir)
            region = RG_KDIRECT;
        else if (is_kernel_i)
            region = RG_MAPPED;
        else
            region = RG_BAD;
    end

    // region to result
    always_comb begin
        res_o = RES_TLB;
        pa_o  = '0;
        unique case (region)
            RG_ERL_LOW: begin
                res_o = RES_DIRECT;
                pa_o[ERL_BITS-1:0] = va_raw_i[ERL_BITS-1:0];
            end
            RG_PHYS_WIN: begin
                res_o = RES_DIRECT;
                pa_o[PHYS_BITS-1:0] = va_raw_i[PHYS_BITS-1:0];
            end
            RG_KDIRECT: begin
                res_o = RES_DIRECT;
                pa_o[KDIR_BITS-1:0] = va_n_i[KDIR_BITS-1:0];
            end
            RG_MAPPED: res_o = RES_TLB;
            RG_BAD:    res_o = wr_i ? RES_ADES : RES_ADEL;
            default:   res_o = wr_i ? RES_ADES : RES_ADEL;
        endcase
    end

endmodule

// File: rtl/vaseg_decoder.sv
module vaseg_decoder
    import vaseg_pkg::*;
#(
    parameter int VA_W      = 64,
    parameter int PA_W      = 64,
    parameter int NARROW_W  = 32,
    parameter int WIDE_USER = 40,
    parameter int PHYS_BITS = 44,
    parameter int KDIR_BITS = 29,
    parameter int ERL_BITS  = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VA_W-1:0] va_i,
    input  logic            wr_i,
    input  logic [1:0]      mode_i,
    input  logic            exl_i,
    input  logic            erl_i,
    input  logic            ux_i,
    input  logic            kx_i,
    output logic [1:0]      res_o,
    output logic [PA_W-1:0] pa_o
);

    logic            is_kernel;
    logic            is_user;
    logic            is_bad;
    logic            wide;
    logic [VA_W-1:0] va_n;
    logic            in_user;
    vaseg_res_e      res_c;
    logic [PA_W-1:0] pa_c;
    vaseg_res_e      res_q;
    logic [PA_W-1:0] pa_q;

    vaseg_mode u_mode (
        .mode_i      (mode_i),
        .exl_i       (exl_i),
        .erl_i       (erl_i),
        .ux_i        (ux_i),
        .kx_i        (kx_i),
        .is_kernel_o (is_kernel),
        .is_user_o   (is_user),
        .is_bad_o    (is_bad),
        .wide_o      (wide)
    );

    vaseg_norm #(
        .VA_W      (VA_W),
        .NARROW_W  (NARROW_W),
        .WIDE_USER (WIDE_USER)
    ) u_norm (
        .va_i      (va_i),
        .wide_i    (wide),
        .va_n_o    (va_n),
        .in_user_o (in_user)
    );

    vaseg_region #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .PHYS_BITS (PHYS_BITS),
        .KDIR_BITS (KDIR_BITS),
        .ERL_BITS  (ERL_BITS)
    ) u_region (
        .va_raw_i    (va_i),
        .va_n_i      (va_n),
        .in_user_i   (in_user && (is_user || is_kernel)),
        .is_kernel_i (is_kernel),
        .is_bad_i    (is_bad),
        .erl_i       (erl_i),
        .wr_i        (wr_i),
        .res_o       (res_c),
        .pa_o        (pa_c)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= RES_TLB;
            pa_q  <= '0;
        end else begin
            res_q <= res_c;
            pa_q  <= pa_c;
        end
    end

    assign res_o = res_q;
    assign pa_o  = pa_q;

endmodule

// File: rtl/vaseg_decoder_chk.sv
module vaseg_decoder_chk #(
    parameter int PA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_i,
    input logic [1:0]      mode_i,
    input logic            exl_i,
    input logic            erl_i,
    input logic [1:0]      res_o,
    input logic [PA_W-1:0] pa_o
);

    logic live_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    // R12
    pa_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_o != 2'b00) |-> (pa_o == '0));

    // R11
    ades_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && res_o == 2'b11) |-> $past(wr_i));

    // R11
    adel_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && res_o == 2'b10) |-> !$past(wr_i));

    // R3
    err_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && res_o[1]) |-> !$past(exl_i || erl_i));

    // R4
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && $past(!exl_i && !erl_i && mode_i[0])) |-> res_o[1]);

    // R9
    direct_kernel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && res_o == 2'b00) |-> $past(exl_i || erl_i || mode_i == 2'b00));

endmodule

bind vaseg_decoder vaseg_decoder_chk #(.PA_W(PA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (wr_i),
    .mode_i (mode_i),
    .exl_i  (exl_i),
    .erl_i  (erl_i),
    .res_o  (res_o),
    .pa_o   (pa_o)
);

// File: tb/tb_vaseg_decoder.sv
module tb_vaseg_decoder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] va;
    logic        wr;
    logic [1:0]  mode;
    logic        exl, erl, ux, kx;
    logic [1:0]  res;
    logic [63:0] pa;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    vaseg_decoder dut (
        .clk(clk), .rst_n(rst_n), .va_i(va), .wr_i(wr), .mode_i(mode),
        .exl_i(exl), .erl_i(erl), .ux_i(ux), .kx_i(kx),
        .res_o(res), .pa_o(pa)
    );

    // {req, va, wr, mode, exl, erl, ux, kx, exp_res, exp_pa}
    localparam int NV = 30;
    localparam logic [144:0] VECS [NV] = '{
        {8'd7,  64'h0000000012345678, 1'b0, 2'b10, 4'b0000, 2'b01, 64'h0},               // R7
        {8'd11, 64'h0000000080000000, 1'b0, 2'b10, 4'b0000, 2'b10, 64'h0},               // R11
        {8'd11, 64'h0000000080000000, 1'b1, 2'b10, 4'b0000, 2'b11, 64'h0},               // R11
        {8'd7,  64'hdeadbeef00001000, 1'b0, 2'b10, 4'b0000, 2'b01, 64'h0},               // R7
        {8'd8,  64'h000000ffffffffff, 1'b0, 2'b10, 4'b0010, 2'b01, 64'h0},               // R8
        {8'd8,  64'h0000010000000000, 1'b0, 2'b10, 4'b0010, 2'b10, 64'h0},               // R8
        {8'd8,  64'h0000000080000000, 1'b1, 2'b10, 4'b0010, 2'b01, 64'h0},               // R8
        {8'd9,  64'h0000000081234567, 1'b0, 2'b00, 4'b0000, 2'b00, 64'h0000000001234567}, // R9
        {8'd9,  64'h00000000bfffffff, 1'b1, 2'b00, 4'b0000, 2'b00, 64'h000000001fffffff}, // R9
        {8'd10, 64'h00000000c0000000, 1'b0, 2'b00, 4'b0000, 2'b01, 64'h0},               // R10
        {8'd9,  64'hffffffffa0000010, 1'b0, 2'b00, 4'b0001, 2'b00, 64'h0000000000000010}, // R9
        {8'd10, 64'hc000000000000000, 1'b1, 2'b00, 4'b0001, 2'b01, 64'h0},               // R10
        {8'd10, 64'h4000000000000000, 1'b0, 2'b00, 4'b0001, 2'b01, 64'h0},               // R10
        {8'd6,  64'h90000123456789ab, 1'b0, 2'b00, 4'b0001, 2'b00, 64'h00000123456789ab}, // R6
        {8'd6,  64'hbfffffff12345678, 1'b0, 2'b00, 4'b0000, 2'b00, 64'h00000fff12345678}, // R6
        {8'd3,  64'hffffffff80000004, 1'b0, 2'b10, 4'b1001, 2'b00, 64'h0000000000000004}, // R3
        {8'd3,  64'h0000000090000000, 1'b0, 2'b10, 4'b1010, 2'b00, 64'h0000000010000000}, // R3
        {8'd5,  64'h000000007ffffffc, 1'b0, 2'b10, 4'b0100, 2'b00, 64'h000000007ffffffc}, // R5
        {8'd5,  64'h0000000080000000, 1'b0, 2'b00, 4'b0100, 2'b00, 64'h0},               // R5
        {8'd5,  64'h0000000000001000, 1'b0, 2'b00, 4'b1000, 2'b01, 64'h0},               // R5
        {8'd5,  64'h0000000000001000, 1'b1, 2'b00, 4'b0101, 2'b00, 64'h0000000000001000}, // R5
        {8'd5,  64'hffffffff00001000, 1'b0, 2'b00, 4'b0100, 2'b01, 64'h0},               // R5
        {8'd4,  64'h0000000000001000, 1'b0, 2'b01, 4'b0000, 2'b10, 64'h0},               // R4
        {8'd4,  64'h0000000000001000, 1'b1, 2'b01, 4'b0000, 2'b11, 64'h0},               // R4
        {8'd4,  64'h0000000000001000, 1'b0, 2'b11, 4'b0000, 2'b10, 64'h0},               // R4
        {8'd3,  64'h0000000000001000, 1'b0, 2'b01, 4'b1000, 2'b01, 64'h0},               // R3
        {8'd6,  64'h9000000000000000, 1'b0, 2'b10, 4'b0000, 2'b01, 64'h0},               // R6
        {8'd11, 64'hffffffff80000000, 1'b1, 2'b10, 4'b0010, 2'b11, 64'h0},               // R11
        {8'd10, 64'hffffffff7fffffff, 1'b0, 2'b00, 4'b0001, 2'b01, 64'h0},               // R10
        {8'd7,  64'h000000007fffffff, 1'b0, 2'b10, 4'b0000, 2'b01, 64'h0}                // R7
    };

    task automatic check(input string req, input logic [1:0] er, input logic [63:0] ep);
        checks++;
        if (res !== er || pa !== ep) begin
            fails++;
            $display("FAIL %s: res=%b pa=%h, expected res=%b pa=%h", req, res, pa, er, ep);
        end
    endtask

    task automatic drive(input logic [144:0] v);
        va   = v[136:73];
        wr   = v[72];
        mode = v[71:70];
        exl  = v[69];
        erl  = v[68];
        ux   = v[67];
        kx   = v[66];
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(VECS[1]);
        repeat (3) @(negedge clk);
        check("R1", 2'b01, 64'h0);
        rst_n = 1'b1;
        #1;
        check("R1", 2'b01, 64'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VECS[i]);
            @(negedge clk);
            check($sformatf("R%0d", VECS[i][144:137]), VECS[i][65:64], VECS[i][63:0]);
        end

        // R2: output holds until the next rising edge, then updates
        @(negedge clk);
        drive(VECS[2]);
        @(negedge clk);
        check("R2", 2'b11, 64'h0);
        drive(VECS[7]);
        #2;
        check("R2", 2'b11, 64'h0);
        @(negedge clk);
        check("R2", 2'b00, 64'h0000000001234567);

        // R12: direct followed by error clears the address
        drive(VECS[5]);
        @(negedge clk);
        check("R12", 2'b10, 64'h0);

        // R1: asynchronous reset in the middle of a run
        drive(VECS[13]);
        @(negedge clk);
        check("R6", 2'b00, 64'h00000123456789ab);
        #2;
        rst_n = 1'b0;
        #1;
        check("R1", 2'b01, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R6", 2'b00, 64'h00000123456789ab);

        finish_run();
    end

endmodule